// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This combinational unit sits beside the datapath of a five-stage in-order integer pipeline. Each cycle it looks at the two source register numbers of the instruction now executing. It compares them with the destination registers carried by the two downstream pipeline registers: the one just after execute and the one just after memory access. For each ALU operand it produces a select code. The code names the newest valid copy of the value: the execute result, the writeback value, or the register-file value read during decode.

The same unit guards against the one dependency that bypassing cannot cover. An instruction in decode may need a register that a load in execute will write, and the load's data only appears after memory access. In that case the unit freezes the program counter and the fetch/decode register and turns the next execute entry into a no-op. One cycle later the load sits in the writeback register, and the dependent instruction receives its data through the writeback path.

The register file is assumed to write in the first half of a cycle and read in the second. A producer three or more instructions back therefore needs no bypass.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (take the execute-stage result) when the post-execute register has its write enable set, a nonzero destination, and a destination equal to that operand's source.
- R2: An operand select is 2'b01 (take the writeback value) when the post-memory register matches the source under the same rule and the post-execute register does not.
- R3: When both downstream registers match the same source, the select is 2'b10, because the post-execute copy is newer in program order.
- R4: When neither downstream register matches, the select is 2'b00 (register-file value).
- R5: Register 0, or any producer whose write enable is clear, never causes a forward, even when the register numbers are equal.
- R6: Operand A's select depends only on source A, and operand B's select depends only on source B. The two operands can carry different codes in the same cycle.
- R7: A load-use stall is raised when the instruction in execute is a load with its write enable set and a nonzero destination, and that destination equals a decode-stage source that the decoded instruction uses.
- R8: No stall is raised when the execute instruction is not a load, when its destination is register 0, or when the matching decode source is marked unused.
- R9: On a stall, the program-counter hold, the fetch/decode hold and the execute-bubble outputs are all set together. Otherwise all three are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RA_W | Decode-stage first source register |
| dec_src_b | input | RA_W | Decode-stage second source register |
| dec_use_a | input | 1 | Decoded instruction reads its first source |
| dec_use_b | input | 1 | Decoded instruction reads its second source |
| exe_src_a | input | RA_W | Execute-stage first source register |
| exe_src_b | input | RA_W | Execute-stage second source register |
| exe_dst | input | RA_W | Execute-stage destination register |
| exe_wr | input | 1 | Execute-stage register write enable |
| exe_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RA_W | Post-execute pipeline register destination |
| mem_wr | input | 1 | Post-execute pipeline register write enable |
| wb_dst | input | RA_W | Post-memory pipeline register destination |
| wb_wr | input | 1 | Post-memory pipeline register write enable |
| sel_a | output | 2 | Operand A source select (00 file, 10 exec result, 01 writeback) |
| sel_b | output | 2 | Operand B source select (same encoding) |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_fd | output | 1 | Keep the fetch/decode register unchanged |
| bubble_ex | output | 1 | Load a no-op with all write enables clear into execute |

## Verification
The assertions assume a pipeline that obeys the stall. When a load sits in the post-execute register, the instruction behind it never reads the load's destination, because that case was stalled a cycle earlier. The unit does not see a load flag for that stage, so it cannot guard against the case itself. The bench draws register numbers from a narrow range so that matches, double matches and register-0 hits are frequent. Every input combination it applies is legal for the unit, including the ones a real pipeline would filter out, because the selects must be correct for all of them.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] dec_src_a,
  input  logic [RA_W-1:0] dec_src_b,
  input  logic            dec_use_a,
  input  logic            dec_use_b,
  input  logic [RA_W-1:0] exe_src_a,
  input  logic [RA_W-1:0] exe_src_b,
  input  logic [RA_W-1:0] exe_dst,
  input  logic            exe_wr,
  input  logic            exe_load,
  input  logic [RA_W-1:0] mem_dst,
  input  logic            mem_wr,
  input  logic [RA_W-1:0] wb_dst,
  input  logic            wb_wr,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic            hold_pc,
  output logic            hold_fd,
  output logic            bubble_ex
);

  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_EXR  = 2'b10;
  localparam logic [1:0] SEL_WBV  = 2'b01;

  logic mem_live, wb_live, ld_live;
  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);
  assign ld_live  = exe_load && exe_wr && (exe_dst != '0);

  logic [RA_W-1:0] src [2];
  logic [1:0]      sel [2];
  assign src[0] = exe_src_a;
  assign src[1] = exe_src_b;

  for (genvar i = 0; i < 2; i++) begin : g_op
    logic hit_mem, hit_wb;
    assign hit_mem = mem_live && (mem_dst == src[i]);
    assign hit_wb  = wb_live  && (wb_dst  == src[i]);
    assign sel[i]  = hit_mem ? SEL_EXR : (hit_wb ? SEL_WBV : SEL_FILE);
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];

  logic stall;
  assign stall = ld_live &&
                 ((dec_use_a && (dec_src_a == exe_dst)) ||
                  (dec_use_b && (dec_src_b == exe_dst)));

  assign hold_pc   = stall;
  assign hold_fd   = stall;
  assign bubble_ex = stall;

endmodule

module fwd_hazard_unit_chk #(
  parameter int RA_W = 5
) (
  input logic [RA_W-1:0] dec_src_a,
  input logic [RA_W-1:0] dec_src_b,
  input logic            dec_use_a,
  input logic            dec_use_b,
  input logic [RA_W-1:0] exe_src_a,
  input logic [RA_W-1:0] exe_dst,
  input logic            exe_wr,
  input logic            exe_load,
  input logic [RA_W-1:0] mem_dst,
  input logic            mem_wr,
  input logic [RA_W-1:0] wb_dst,
  input logic            wb_wr,
  input logic [1:0]      sel_a,
  input logic            hold_pc,
  input logic            hold_fd,
  input logic            bubble_ex
);
  always_comb begin
    if (sel_a == 2'b10)
      a_r1_exr_needs_match: assert (mem_wr && mem_dst == exe_src_a);
    if (sel_a == 2'b01)
      a_r2_wbv_needs_match: assert (wb_wr && wb_dst == exe_src_a);
    if (mem_wr && wb_wr && mem_dst == exe_src_a && wb_dst == exe_src_a && mem_dst != '0)
      a_r3_newest_wins: assert (sel_a == 2'b10);
    if (exe_src_a == '0)
      a_r5_zero_not_forwarded: assert (sel_a == 2'b00);
    a_r4_legal_code: assert (sel_a != 2'b11);
    if (bubble_ex)
      a_r7_stall_needs_load: assert (exe_load && exe_wr && exe_dst != '0 &&
        ((dec_use_a && dec_src_a == exe_dst) || (dec_use_b && dec_src_b == exe_dst)));
    a_r9_stall_outputs_agree: assert (hold_pc == hold_fd && hold_fd == bubble_ex);
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.RA_W(RA_W)) u_chk (
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
  .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
  .exe_src_a(exe_src_a), .exe_dst(exe_dst), .exe_wr(exe_wr), .exe_load(exe_load),
  .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
  .sel_a(sel_a), .hold_pc(hold_pc), .hold_fd(hold_fd), .bubble_ex(bubble_ex)
);

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  localparam int RA_W = 5;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [RA_W-1:0] dec_src_a = 0, dec_src_b = 0, exe_src_a = 0, exe_src_b = 0;
  logic [RA_W-1:0] exe_dst = 0, mem_dst = 0, wb_dst = 0;
  logic dec_use_a = 0, dec_use_b = 0, exe_wr = 0, exe_load = 0, mem_wr = 0, wb_wr = 0;
  logic [1:0] sel_a, sel_b;
  logic hold_pc, hold_fd, bubble_ex;

  int checks = 0, errors = 0;
  bit done = 0;

  fwd_hazard_unit #(.RA_W(RA_W)) uut (.*);

  // behavioural reference: producers listed newest first
  function automatic int ref_sel(input int s);
    int dst[2];
    bit wr[2];
    int code[2];
    dst = '{int'(mem_dst), int'(wb_dst)};
    wr  = '{mem_wr, wb_wr};
    code = '{2, 1};
    foreach (dst[k]) if (wr[k] && dst[k] != 0 && dst[k] == s) return code[k];
    return 0;
  endfunction

  function automatic string tag_for(input int s, input int e);
    bit wbm = wb_wr && wb_dst != 0 && int'(wb_dst) == s;
    if (e == 2) return wbm ? "R3" : "R1";
    if (e == 1) return "R2";
    if ((int'(mem_dst) == s) || (int'(wb_dst) == s)) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare();
    int ea, eb;
    bit st;
    string stag;
    ea = ref_sel(int'(exe_src_a));
    eb = ref_sel(int'(exe_src_b));
    chk(tag_for(int'(exe_src_a), ea), int'(sel_a), ea);
    chk(tag_for(int'(exe_src_b), eb), int'(sel_b), eb);
    st = 0;
    if (exe_load && exe_wr && exe_dst != 0) begin
      if (dec_use_a && dec_src_a == exe_dst) st = 1;
      if (dec_use_b && dec_src_b == exe_dst) st = 1;
    end
    stag = st ? "R7" : "R8";
    chk(stag, int'(bubble_ex), int'(st));
    chk("R9", int'(hold_pc), int'(st));
    chk("R9", int'(hold_fd), int'(st));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    // idle state: nothing forwarded, no stall (R4, R9)
    step();
    // R1: directly ahead producer
    exe_src_a = 3; mem_dst = 3; mem_wr = 1; step();
    // R2: two ahead
    mem_wr = 0; wb_dst = 3; wb_wr = 1; step();
    // R3: both match, newest wins
    mem_wr = 1; step();
    chk("R3", int'(sel_a), 2);
    // R5: register 0 and disabled write
    exe_src_a = 0; mem_dst = 0; wb_dst = 0; step();
    chk("R5", int'(sel_a), 0);
    exe_src_a = 4; mem_dst = 4; mem_wr = 0; wb_dst = 4; wb_wr = 0; step();
    chk("R5", int'(sel_a), 0);
    // R6: independent operands
    exe_src_a = 6; exe_src_b = 7; mem_dst = 6; mem_wr = 1; wb_dst = 7; wb_wr = 1; step();
    chk("R6", int'(sel_a), 2);
    chk("R6", int'(sel_b), 1);
    // R7: load-use on source B only
    exe_load = 1; exe_wr = 1; exe_dst = 9; dec_src_b = 9; dec_use_b = 1; step();
    chk("R7", int'(bubble_ex), 1);
    // R8: unused source, non-load, zero dest
    dec_use_b = 0; step();
    chk("R8", int'(hold_pc), 0);
    dec_use_b = 1; exe_load = 0; step();
    chk("R8", int'(hold_fd), 0);
    exe_load = 1; exe_dst = 0; dec_src_b = 0; step();
    chk("R8", int'(bubble_ex), 0);
    // random sweep over a narrow register range
    for (int n = 0; n < 3000; n++) begin
      dec_src_a = RA_W'($urandom_range(0, 3));
      dec_src_b = RA_W'($urandom_range(0, 3));
      exe_src_a = RA_W'($urandom_range(0, 3));
      exe_src_b = RA_W'($urandom_range(0, 3));
      exe_dst   = RA_W'($urandom_range(0, 3));
      mem_dst   = RA_W'($urandom_range(0, 3));
      wb_dst    = RA_W'($urandom_range(0, 3));
      {dec_use_a, dec_use_b, exe_wr, exe_load, mem_wr, wb_wr} = 6'($urandom);
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule